// File: doc/BRIEF.md
# Memory-Test Address Sequencer

This block produces the address stream that a built-in memory self-test engine uses to walk a single RAM once. A one-cycle start pulse begins a pass. From that point the block presents one address per clock cycle, counting up or down, until it has covered every word of the selected RAM. It then raises a one-cycle completion flag and returns to idle. The RAM size comes from a 3-bit row code, and the number of column bits is a parameter.

Compiled RAMs do not always order their two lowest column-address bits in plain binary. For that reason, each of the four RAMs (valid, tag, parity, data) has its own ordering bit in a 4-bit option word. A 2-bit RAM select picks which of those bits applies. When the chosen bit is clear, the two low bits run in binary order. When it is set, the last two steps of each group of four are swapped. The bits above them behave as an ordinary counter that moves one step each time the low pair completes its group of four. The direction, RAM select, option word and row code are all captured at the start pulse and held for the whole pass.

The control is a three-state machine. IDLE waits for a start. WALK issues the addresses. FINISH raises the completion flag for one cycle. The transitions are named as follows: LAUNCH (IDLE to WALK on start), STEP (WALK to WALK while the final address is not yet issued), END (WALK to FINISH on the final address) and RETIRE (FINISH to IDLE, always).

Top module: `mtas_addr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `addr_vld_o`, `last_o` and `pass_done_o` are 0 and `addr_o` is 0.
- R2: A start pulse sampled in IDLE begins a pass on the next cycle. The first address is 0 when counting up and the largest address of the RAM when counting down.
- R3: With the selected option bit at 0, the two low address bits run 00, 01, 10, 11 when counting up and 11, 10, 01, 00 when counting down.
- R4: With the selected option bit at 1, the two low address bits run 00, 01, 11, 10 when counting up and 10, 11, 01, 00 when counting down.
- R5: The option bit in use is `lsb_swap_i[ram_sel_i]`, where bit 0 belongs to the valid RAM, bit 1 to tag, bit 2 to parity and bit 3 to data.
- R6: The address bits above the low pair step by one (up or down, following the direction) only on the cycle after the low pair completes its four-step group.
- R7: The RAM has 2^min(code+ROW_BASE_LOG, ROW_MAX_LOG) rows. With the defaults this is 8 rows at code 0 and no more than 512 rows. A pass covers rows×2^COL_W addresses. All `addr_o` bits above ROW_MAX_LOG+COL_W are 0.
- R8: `last_o` is high only while the final address of a pass is shown. `pass_done_o` is high for exactly the following cycle, with `addr_vld_o` low, and the block is idle after that.
- R9: A start pulse that arrives during WALK or FINISH is ignored. The pass runs to its normal end, and no new pass begins after FINISH.
- R10: Changes to the direction, RAM select, option word or row code during a pass have no effect on that pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a pass |
| dir_down_i | input | 1 | 1 = count down, 0 = count up |
| ram_sel_i | input | 2 | RAM under test: 0 valid, 1 tag, 2 parity, 3 data |
| lsb_swap_i | input | 4 | Per-RAM low-bit ordering option, one bit per RAM |
| rows_code_i | input | 3 | Row-count code |
| addr_o | output | 17 | Current address |
| addr_vld_o | output | 1 | High while a pass address is shown |
| last_o | output | 1 | High on the final address of a pass |
| pass_done_o | output | 1 | One-cycle pulse after the final address |

## Verification
The bench builds the block with COL_W=2, so the two ordered bits make up the entire column field and every step of the upper count is a row step. The other parameters keep their defaults, so row code 0 gives a short 32-address pass that shows the ordering in both directions. Row codes 6 and 7 both reach the 512-row ceiling, which exercises the clamp and the largest address. Pokes on start and on every configuration input during WALK and during FINISH show that a running pass holds its settings.

// File: rtl/mtas_pkg.sv
package mtas_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_FINISH = 2'd2
    } mtas_state_e;

endpackage

// File: rtl/mtas_row_limit.sv
// Converts a row code into the highest row index, clamped at 2^ROW_MAX_LOG rows.
module mtas_row_limit #(
    parameter int CODE_W       = 3,
    parameter int ROW_BASE_LOG = 3,
    parameter int ROW_MAX_LOG  = 9
) (
    input  logic [CODE_W-1:0]      code_i,
    output logic [ROW_MAX_LOG-1:0] row_max_o
);
    localparam int SPAN_W = ROW_MAX_LOG + 1;

    int                lg;
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] span_m1;

    always_comb begin
        lg = int'(code_i) + ROW_BASE_LOG;
        if (lg > ROW_MAX_LOG) begin
            lg = ROW_MAX_LOG;
        end
        span    = SPAN_W'(1) << lg;
        span_m1 = span - SPAN_W'(1);
    end

    assign row_max_o = span_m1[ROW_MAX_LOG-1:0];
endmodule

// File: rtl/mtas_lsb_map.sv
// Maps the logical low pair onto the physical pair: binary, or with steps 2 and 3 swapped.
module mtas_lsb_map (
    input  logic       swap_i,
    input  logic [1:0] idx_i,
    output logic [1:0] phys_o
);
    always_comb begin
        if (swap_i) begin
            phys_o = {idx_i[1], idx_i[1] ^ idx_i[0]};
        end else begin
            phys_o = idx_i;
        end
    end
endmodule

// File: rtl/mtas_idx_counter.sv
// Logical word index; the low pair carries into the upper bits like any binary counter.
module mtas_idx_counter #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W-1:0] load_val_i,
    input  logic             step_i,
    input  logic             down_i,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load_i) begin
            idx_q <= load_val_i;
        end else if (step_i) begin
            idx_q <= down_i ? (idx_q - IDX_W'(1)) : (idx_q + IDX_W'(1));
        end
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/mtas_addr_seq.sv
module mtas_addr_seq #(
    parameter int ADDR_W       = 17,
    parameter int COL_W        = 3,
    parameter int ROW_MAX_LOG  = 9,
    parameter int ROW_BASE_LOG = 3,
    parameter int CODE_W       = 3,
    parameter int RAM_CNT      = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       dir_down_i,
    input  logic [$clog2(RAM_CNT)-1:0] ram_sel_i,
    input  logic [RAM_CNT-1:0]         lsb_swap_i,
    input  logic [CODE_W-1:0]          rows_code_i,
    output logic [ADDR_W-1:0]          addr_o,
    output logic                       addr_vld_o,
    output logic                       last_o,
    output logic                       pass_done_o
);
    import mtas_pkg::*;

    localparam int IDX_W = ROW_MAX_LOG + COL_W;
    localparam int PAD_W = ADDR_W - IDX_W;
    localparam int SEL_W = $clog2(RAM_CNT);

    mtas_state_e state_q, state_d;

    logic                   dir_q;
    logic [SEL_W-1:0]       ram_q;
    logic [RAM_CNT-1:0]     swap_q;
    logic [CODE_W-1:0]      code_q;
    logic [CODE_W-1:0]      code_sel;
    logic [ROW_MAX_LOG-1:0] row_max;
    logic [IDX_W-1:0]       max_idx;
    logic [IDX_W-1:0]       idx;
    logic [IDX_W-1:0]       load_val;
    logic [1:0]             low_phys;
    logic                   launch;
    logic                   walking;
    logic                   at_end;

    // The row code is taken from the live input only while idle, so the launch address
    // and the end test of a running pass both use the captured value.
    assign code_sel = (state_q == ST_IDLE) ? rows_code_i : code_q;

    mtas_row_limit #(
        .CODE_W      (CODE_W),
        .ROW_BASE_LOG(ROW_BASE_LOG),
        .ROW_MAX_LOG (ROW_MAX_LOG)
    ) u_row_limit (
        .code_i   (code_sel),
        .row_max_o(row_max)
    );

    assign max_idx  = {row_max, {COL_W{1'b1}}};
    assign launch   = (state_q == ST_IDLE) && start_i;
    assign walking  = (state_q == ST_WALK);
    assign at_end   = dir_q ? (idx == '0) : (idx == max_idx);
    assign load_val = dir_down_i ? max_idx : '0;

    mtas_idx_counter #(
        .IDX_W(IDX_W)
    ) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (launch),
        .load_val_i(load_val),
        .step_i    (walking && !at_end),
        .down_i    (dir_q),
        .idx_o     (idx)
    );

    mtas_lsb_map u_lsb_map (
        .swap_i(swap_q[ram_q]),
        .idx_i (idx[1:0]),
        .phys_o(low_phys)
    );

    // Pass settings captured on LAUNCH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            ram_q  <= '0;
            swap_q <= '0;
            code_q <= '0;
        end else if (launch) begin
            dir_q  <= dir_down_i;
            ram_q  <= ram_sel_i;
            swap_q <= lsb_swap_i;
            code_q <= rows_code_i;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: LAUNCH, STEP, END, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_WALK;
            ST_WALK:   if (at_end)  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        addr_vld_o  = 1'b0;
        last_o      = 1'b0;
        pass_done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_WALK: begin
                addr_vld_o = 1'b1;
                last_o     = at_end;
            end
            ST_FINISH: pass_done_o = 1'b1;
            default: begin
            end
        endcase
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign addr_o = {{PAD_W{1'b0}}, idx[IDX_W-1:2], low_phys};
        end else begin : g_nopad
            assign addr_o = {idx[IDX_W-1:2], low_phys};
        end
    endgenerate
endmodule

// File: rtl/mtas_addr_seq_chk.sv
module mtas_addr_seq_chk #(
    parameter int ADDR_W = 17,
    parameter int USED_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              dir_down_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              addr_vld_o,
    input logic              last_o,
    input logic              pass_done_o
);
    AST_UP_PASS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !addr_vld_o && !pass_done_o && !dir_down_i) |=> (addr_vld_o && addr_o == '0)); // R2

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld_o |-> ((addr_o >> USED_W) == '0)); // R7

    AST_LAST_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> addr_vld_o); // R8

    AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (pass_done_o && !addr_vld_o)); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done_o |=> (!pass_done_o && !addr_vld_o)); // R9

    AST_WALK_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o && !last_o) |=> (addr_vld_o && !pass_done_o)); // R9
endmodule

bind mtas_addr_seq mtas_addr_seq_chk #(
    .ADDR_W(ADDR_W),
    .USED_W(ROW_MAX_LOG + COL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dir_down_i (dir_down_i),
    .addr_o     (addr_o),
    .addr_vld_o (addr_vld_o),
    .last_o     (last_o),
    .pass_done_o(pass_done_o)
);

// File: tb/mtas_addr_seq_tb_top.sv
`timescale 1ns/1ps
module mtas_addr_seq_tb_top;
    localparam int ADDR_W = 17;
    localparam int COL_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              dir_down_i = 1'b0;
    logic [1:0]        ram_sel_i = '0;
    logic [3:0]        lsb_swap_i = '0;
    logic [2:0]        rows_code_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic              addr_vld_o;
    logic              last_o;
    logic              pass_done_o;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    done_cnt = 0;
    string cur_tag = "R3";

    logic [ADDR_W-1:0] exp_addr_q[$];
    bit                exp_last_q[$];

    always #10 clk = ~clk;

    mtas_addr_seq #(
        .ADDR_W(ADDR_W),
        .COL_W (COL_W)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dir_down_i (dir_down_i),
        .ram_sel_i  (ram_sel_i),
        .lsb_swap_i (lsb_swap_i),
        .rows_code_i(rows_code_i),
        .addr_o     (addr_o),
        .addr_vld_o (addr_vld_o),
        .last_o     (last_o),
        .pass_done_o(pass_done_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected addresses as the design shows them
    initial begin
        bit prev_last = 1'b0;
        bit prev_done = 1'b0;
        int item = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev_last = 1'b0;
                prev_done = 1'b0;
                item = 0;
                continue;
            end
            if (prev_done) begin
                chk(!addr_vld_o && !pass_done_o, "R9", "idle after done (vld,done)",
                    {addr_vld_o, pass_done_o}, 0);
            end
            if (addr_vld_o) begin
                if (exp_addr_q.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected address", addr_o, 0);
                end else begin
                    logic [ADDR_W-1:0] ea;
                    bit el;
                    ea = exp_addr_q.pop_front();
                    el = exp_last_q.pop_front();
                    chk(addr_o == ea, (item == 0) ? "R2" : cur_tag, "address", addr_o, ea);
                    chk(last_o == el, "R8", "last flag", last_o, el);
                end
                item++;
            end
            if (pass_done_o) begin
                chk(prev_last, "R8", "done without preceding last", prev_last, 1);
                chk(exp_addr_q.size() == 0, "R8", "addresses left at done",
                    exp_addr_q.size(), 0);
                done_cnt++;
                item = 0;
            end
            prev_last = last_o && addr_vld_o;
            prev_done = pass_done_o;
        end
    end

    // Driver: pushes the expected stream, then runs one pass
    task automatic run_pass(input bit dn, input int ram, input logic [3:0] field,
                            input int code, input string tag, input bit poke);
        int  lg;
        int  n;
        int  k;
        int  done_before;
        bit  opt;
        lg = code + 3;
        if (lg > 9) lg = 9;
        n   = 1 << (lg + COL_W);
        opt = field[ram];
        for (int i = 0; i < n; i++) begin
            int j;
            logic [1:0] lo;
            logic [1:0] ph;
            j  = dn ? (n - 1 - i) : i;
            lo = 2'(j);
            ph = opt ? {lo[1], lo[1] ^ lo[0]} : lo;
            exp_addr_q.push_back(ADDR_W'((j & ~3) | int'(ph)));
            exp_last_q.push_back(i == n - 1);
        end
        cur_tag     = tag;
        done_before = done_cnt;
        @(posedge clk); #2;
        dir_down_i  = dn;
        ram_sel_i   = 2'(ram);
        lsb_swap_i  = field;
        rows_code_i = 3'(code);
        start_i     = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
        if (poke) begin
            k = n / 2;
            repeat (k) @(posedge clk);
            #2;
            start_i     = 1'b1;
            dir_down_i  = ~dn;
            ram_sel_i   = ram_sel_i + 2'd1;
            lsb_swap_i  = ~field;
            rows_code_i = rows_code_i ^ 3'd1;
            @(posedge clk); #2;
            start_i = 1'b0;
            repeat (n - k - 1) @(posedge clk);
            #2;
            start_i = 1'b1;   // sampled during FINISH
            @(posedge clk); #2;
            start_i = 1'b0;
            repeat (3) @(posedge clk);
        end else begin
            repeat (n + 3) @(posedge clk);
        end
        #2;
        chk(done_cnt == done_before + 1, "R8", "one done pulse per pass",
            done_cnt - done_before, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!addr_vld_o && !last_o && !pass_done_o && addr_o == '0, "R1",
            "outputs in reset", {addr_vld_o, last_o, pass_done_o, addr_o}, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!addr_vld_o && !last_o && !pass_done_o && addr_o == '0, "R1",
            "outputs after reset", {addr_vld_o, last_o, pass_done_o, addr_o}, 0);

        run_pass(1'b0, 0, 4'b0000, 0, "R3", 1'b0);
        run_pass(1'b1, 0, 4'b0000, 0, "R3", 1'b0);
        run_pass(1'b0, 1, 4'b0010, 0, "R4", 1'b0);
        run_pass(1'b1, 1, 4'b0010, 0, "R4", 1'b0);
        run_pass(1'b0, 2, 4'b1011, 0, "R5", 1'b0);
        run_pass(1'b1, 3, 4'b1000, 1, "R6", 1'b0);
        run_pass(1'b0, 0, 4'b0001, 0, "R9,R10", 1'b1);
        run_pass(1'b1, 2, 4'b0100, 1, "R9,R10", 1'b1);
        run_pass(1'b0, 3, 4'b1000, 7, "R7", 1'b0);
        run_pass(1'b1, 1, 4'b0010, 6, "R7", 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #3_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule